// File: doc/BRIEF.md
# Packed Default Attribute Loader

This block turns a stream of 32-bit configuration writes into four-component vertex attribute vectors. Each component is a 24-bit floating-point value. Three consecutive data writes carry one full vector, 96 bits in total. Once the third word arrives, the block splits the words into components and sends the vector to one of two places. Below a fixed table size it goes to a per-index default-attribute table. At the index one past the last table entry it goes to an immediate-mode vertex assembly buffer instead.

A separate write of the setup index register chooses where the following vectors go. In table mode the index advances by one after every vector. In immediate mode a slot counter walks through the attribute slots up to a configured maximum. When the last slot is filled, the counter wraps to zero and the block pulses a vertex-ready strobe. A setup index write also raises a request to reset the downstream pipeline. That request is handed over with the next assembled immediate vertex.

The block does no floating-point arithmetic. It does not run the shader and does not assemble primitives. Its outputs are write strobes, addresses and the vector for storage that sits outside it.

Top module: `packed_attr_loader`

## Requirements
- R1: A word counter counts data writes from 0 to 2. The write that arrives with the counter at 2 completes a vector and returns the counter to 0. Any other data write stores its word and increments the counter.
- R2: In `attrVec`, bits [95:72] hold w, [71:48] hold z, [47:24] hold y and [23:0] hold x. Here w is word0[31:8], z is {word0[7:0], word1[31:16]}, y is {word1[15:0], word2[31:24]} and x is word2[23:0]. Word0 is the first of the three writes.
- R3: The strobes and `attrVec` for a completed vector appear in the cycle after the completing write. Strobes last exactly one cycle. `attrVec` keeps its value until the next completed vector.
- R4: If the setup index is 16 or more when a vector completes, the block pulses `idxError`. No table or immediate strobe fires, and the index stays as it is.
- R5: If the setup index is below 15, the block pulses `tblWrEn` with `tblIdx` equal to that index. The index then increments by one.
- R6: If the setup index equals 15, the block pulses `immWrEn` with `immSlot` equal to the current slot counter. If the counter is below `maxAttrIdx`, the counter increments. The index stays at 15.
- R7: If the slot counter is not below `maxAttrIdx` when an immediate vector completes, the counter wraps to 0. In the same cycle as `immWrEn`, the block pulses `vtxReady`, and `vtxRestart` carries the value the reset request had before this vertex.
- R8: A setup index write loads `setupIdx`, clears the word counter and the slot counter, and sets `pipeResetReq`. `pipeResetReq` drops in the cycle in which `vtxReady` pulses.
- R9: If a setup index write and a data write occur in the same cycle, the data write is ignored.
- R10: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idxWrEn | input | 1 | Setup index register write |
| idxWrData | input | 5 | New setup index |
| wordWrEn | input | 1 | Packed data word write |
| wordWrData | input | 32 | Packed data word |
| maxAttrIdx | input | 4 | Highest immediate attribute slot in use |
| tblWrEn | output | 1 | Default table write strobe |
| tblIdx | output | 4 | Default table entry written |
| immWrEn | output | 1 | Immediate buffer write strobe |
| immSlot | output | 4 | Immediate buffer slot written |
| attrVec | output | 96 | Unpacked vector {w,z,y,x} |
| vtxReady | output | 1 | Immediate vertex complete pulse |
| vtxRestart | output | 1 | Pipeline reset accompanies this vertex |
| pipeResetReq | output | 1 | Pending pipeline reset request |
| idxError | output | 1 | Vector discarded, index out of range |
| setupIdx | output | 5 | Current setup index |

## Verification
The assertions assume that `maxAttrIdx` is a value below 16 and that it does not change while an immediate vertex is partly assembled. The stimulus changes it only right after a setup index write, and the block clears the slot counter at that point. The checks also assume that reset is held until data writes begin, so no capture is pending when reset is released. The bench keeps both write enables low during reset. It covers a setup index write and a data write in the same cycle, a word sequence broken off by an index write, and index values 14, 15 and 20.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef struct packed {
    logic       capEn;
    logic [1:0] capSel;
    logic       commit;
  } dp_strobe_t;
endpackage

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_pkg::*;
#(
  parameter int TABLE_DEPTH = 15,
  parameter int IDX_W       = 5,
  parameter int SLOT_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idxWrEn,
  input  logic [IDX_W-1:0]  idxWrData,
  input  logic              wordWrEn,
  input  logic [SLOT_W-1:0] maxAttrIdx,
  output dp_strobe_t        strobe,
  output logic              tblWrEn,
  output logic [$clog2(TABLE_DEPTH)-1:0] tblIdx,
  output logic              immWrEn,
  output logic [SLOT_W-1:0] immSlot,
  output logic              vtxReady,
  output logic              vtxRestart,
  output logic              pipeResetReq,
  output logic              idxError,
  output logic [IDX_W-1:0]  setupIdx
);
  localparam int TIDX_W = $clog2(TABLE_DEPTH);
  localparam logic [IDX_W-1:0] IMM_IDX = IDX_W'(TABLE_DEPTH);

  logic [1:0]        wordCnt;
  logic [SLOT_W-1:0] slotCnt;

  always_comb begin
    strobe.capEn  = wordWrEn & ~idxWrEn;
    strobe.capSel = wordCnt;
    strobe.commit = wordWrEn & ~idxWrEn & (wordCnt == 2'd2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wordCnt      <= '0;
      slotCnt      <= '0;
      setupIdx     <= '0;
      pipeResetReq <= 1'b0;
      tblWrEn      <= 1'b0;
      tblIdx       <= '0;
      immWrEn      <= 1'b0;
      immSlot      <= '0;
      vtxReady     <= 1'b0;
      vtxRestart   <= 1'b0;
      idxError     <= 1'b0;
    end else begin
      tblWrEn    <= 1'b0;
      immWrEn    <= 1'b0;
      vtxReady   <= 1'b0;
      vtxRestart <= 1'b0;
      idxError   <= 1'b0;
      if (idxWrEn) begin
        setupIdx     <= idxWrData;
        wordCnt      <= '0;
        slotCnt      <= '0;
        pipeResetReq <= 1'b1;
      end else if (strobe.commit) begin
        wordCnt <= '0;
        if (setupIdx > IMM_IDX) begin
          idxError <= 1'b1;
        end else if (setupIdx < IMM_IDX) begin
          tblWrEn  <= 1'b1;
          tblIdx   <= setupIdx[TIDX_W-1:0];
          setupIdx <= setupIdx + 1'b1;
        end else begin
          immWrEn <= 1'b1;
          immSlot <= slotCnt;
          if (slotCnt >= maxAttrIdx) begin
            slotCnt      <= '0;
            vtxReady     <= 1'b1;
            vtxRestart   <= pipeResetReq;
            pipeResetReq <= 1'b0;
          end else begin
            slotCnt <= slotCnt + 1'b1;
          end
        end
      end else if (strobe.capEn) begin
        wordCnt <= wordCnt + 1'b1;
      end
    end
  end

  // R1: the word counter never reaches 3
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    wordCnt != 2'd3);
  // R4: an error is flagged only while the index is out of range
  a_r4_err_idx: assert property (@(posedge clk) disable iff (!rst_n)
    idxError |-> (setupIdx > IMM_IDX));
  // R5: a table write leaves the index one past the written entry
  a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    tblWrEn |-> (setupIdx == IDX_W'({1'b0, tblIdx}) + 1'b1));
  // R3/R4/R5/R6: one destination at most per vector
  a_r3_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tblWrEn, immWrEn, idxError}));
  // R7: a vertex pulse comes with an immediate write and a wrapped counter
  a_r7_vtx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    vtxReady |-> (immWrEn && slotCnt == '0));
  // R8: the reset request is gone once a vertex is issued
  a_r8_req_clear: assert property (@(posedge clk) disable iff (!rst_n)
    vtxReady |-> !pipeResetReq);
  // R9: after an index write the word counter starts over
  a_r9_idx_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(idxWrEn) |-> (wordCnt == 2'd0 && slotCnt == '0));
endmodule

// File: rtl/pal_datapath.sv
module pal_datapath
  import pal_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int COMP_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dp_strobe_t          strobe,
  input  logic [WORD_W-1:0]   wordWrData,
  output logic [4*COMP_W-1:0] attrVec
);
  localparam int VEC_W = 4 * COMP_W;

  logic [WORD_W-1:0] word0, word1;
  logic [3*WORD_W-1:0] packedBits;
  logic [VEC_W-1:0] unpacked;

  assign packedBits = {word0, word1, wordWrData};

  // component k (0 = x .. 3 = w) lies k components up from the last word's LSB
  for (genvar k = 0; k < 4; k++) begin : g_comp
    assign unpacked[k*COMP_W +: COMP_W] = packedBits[k*COMP_W +: COMP_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word0   <= '0;
      word1   <= '0;
      attrVec <= '0;
    end else if (strobe.capEn) begin
      if (strobe.capSel == 2'd0) word0 <= wordWrData;
      if (strobe.capSel == 2'd1) word1 <= wordWrData;
      if (strobe.commit) attrVec <= unpacked;
    end
  end

  // R3: the vector holds between completed vectors
  a_r3_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe.commit) |-> $stable(attrVec));
  // R2: the x component is the low part of the completing word
  a_r2_x_field: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe.commit) |-> (attrVec[COMP_W-1:0] == $past(wordWrData[COMP_W-1:0])));
endmodule

// File: rtl/packed_attr_loader.sv
module packed_attr_loader
  import pal_pkg::*;
#(
  parameter int TABLE_DEPTH = 15,
  parameter int IDX_W       = 5,
  parameter int SLOT_W      = 4,
  parameter int WORD_W      = 32,
  parameter int COMP_W      = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idxWrEn,
  input  logic [IDX_W-1:0]    idxWrData,
  input  logic                wordWrEn,
  input  logic [WORD_W-1:0]   wordWrData,
  input  logic [SLOT_W-1:0]   maxAttrIdx,
  output logic                tblWrEn,
  output logic [$clog2(TABLE_DEPTH)-1:0] tblIdx,
  output logic                immWrEn,
  output logic [SLOT_W-1:0]   immSlot,
  output logic [4*COMP_W-1:0] attrVec,
  output logic                vtxReady,
  output logic                vtxRestart,
  output logic                pipeResetReq,
  output logic                idxError,
  output logic [IDX_W-1:0]    setupIdx
);
  dp_strobe_t strobe;

  pal_ctrl #(.TABLE_DEPTH(TABLE_DEPTH), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .idxWrEn(idxWrEn), .idxWrData(idxWrData),
    .wordWrEn(wordWrEn), .maxAttrIdx(maxAttrIdx), .strobe(strobe),
    .tblWrEn(tblWrEn), .tblIdx(tblIdx), .immWrEn(immWrEn), .immSlot(immSlot),
    .vtxReady(vtxReady), .vtxRestart(vtxRestart), .pipeResetReq(pipeResetReq),
    .idxError(idxError), .setupIdx(setupIdx)
  );

  pal_datapath #(.WORD_W(WORD_W), .COMP_W(COMP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wordWrData(wordWrData),
    .attrVec(attrVec)
  );
endmodule

// File: tb/tb_packed_attr_loader.sv
module tb_packed_attr_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idxWrEn = 1'b0;
  logic [4:0] idxWrData = '0;
  logic wordWrEn = 1'b0;
  logic [31:0] wordWrData = '0;
  logic [3:0] maxAttrIdx = '0;
  logic tblWrEn, immWrEn, vtxReady, vtxRestart, pipeResetReq, idxError;
  logic [3:0] tblIdx, immSlot;
  logic [95:0] attrVec;
  logic [4:0] setupIdx;

  always #2.5 clk = ~clk;

  packed_attr_loader dut (.*);

  int checks = 0, fails = 0, cycles = 0;
  bit started = 0, done = 0;

  // behavioural reference
  int mCnt, mIdx, mSlot;
  bit mFlag, eTbl, eImm, eVtx, eRst, eErr;
  int eTblIdx, eSlot;
  logic [31:0] mWords[3];
  logic [95:0] eVec;

  always @(posedge clk) begin
    cycles++;
    started = 1;
    eTbl = 0; eImm = 0; eVtx = 0; eRst = 0; eErr = 0;
    if (!rst_n) begin
      mCnt = 0; mIdx = 0; mSlot = 0; mFlag = 0; eTblIdx = 0; eSlot = 0; eVec = '0;
    end else if (idxWrEn) begin
      mIdx = idxWrData; mCnt = 0; mSlot = 0; mFlag = 1;
    end else if (wordWrEn) begin
      mWords[mCnt] = wordWrData;
      if (mCnt == 2) begin
        logic [23:0] cx, cy, cz, cw;
        mCnt = 0;
        cw = mWords[0][31:8];
        cz = {mWords[0][7:0], mWords[1][31:16]};
        cy = {mWords[1][15:0], mWords[2][31:24]};
        cx = mWords[2][23:0];
        eVec = {cw, cz, cy, cx};
        if (mIdx >= 16) eErr = 1;
        else if (mIdx < 15) begin eTbl = 1; eTblIdx = mIdx; mIdx++; end
        else begin
          eImm = 1; eSlot = mSlot;
          if (mSlot >= maxAttrIdx) begin
            mSlot = 0; eVtx = 1; eRst = mFlag; mFlag = 0;
          end else mSlot++;
        end
      end else mCnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      if (!rst_n) chk({tblWrEn, immWrEn, vtxReady, pipeResetReq, idxError, setupIdx, attrVec} == '0,
                      "R10", "reset outputs", {tblWrEn, immWrEn, setupIdx}, '0);
      chk(tblWrEn == eTbl && (!eTbl || tblIdx == eTblIdx[3:0]), "R5", "table strobe/idx",
          {tblWrEn, tblIdx}, {eTbl, eTblIdx[3:0]});
      chk(setupIdx == mIdx[4:0], "R5", "setup index", setupIdx, mIdx[4:0]);
      chk(immWrEn == eImm && (!eImm || immSlot == eSlot[3:0]), "R6", "immediate strobe/slot",
          {immWrEn, immSlot}, {eImm, eSlot[3:0]});
      chk(vtxReady == eVtx && vtxRestart == eRst, "R7", "vertex pulse/restart",
          {vtxReady, vtxRestart}, {eVtx, eRst});
      chk(pipeResetReq == mFlag, "R8", "reset request", pipeResetReq, mFlag);
      chk(idxError == eErr, "R4", "index error", idxError, eErr);
      chk(attrVec == eVec, "R2", "unpacked vector (R3 hold)", attrVec, eVec);
    end
  end

  logic [31:0] seed = 32'h1234_5678;
  function automatic logic [31:0] nextWord();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed ^ {seed[15:0], seed[31:16]};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); idxWrEn = 0; wordWrEn = 0;
    end
  endtask
  task automatic setIdx(input logic [4:0] v);
    @(negedge clk); idxWrEn = 1; idxWrData = v; wordWrEn = 0;
  endtask
  task automatic sendWord(input logic [31:0] d);
    @(negedge clk); idxWrEn = 0; wordWrEn = 1; wordWrData = d;
  endtask
  task automatic sendVecs(input int n);
    for (int i = 0; i < 3 * n; i++) sendWord(nextWord());
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 20000 && !done) begin
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected<20000", cycles);
    finishRun();
  end

  initial begin
    idle(4);
    rst_n = 1;                                  // R10 checked while low
    idle(2);
    setIdx(5'd0); sendVecs(2); idle(2);         // R1 R2 R5
    sendWord(32'hFFFF_FFFF); sendWord(32'h0);   // partial vector
    setIdx(5'd14);                              // R8: counter cleared
    sendWord(32'hAABB_CCDD); sendWord(32'h1122_3344); sendWord(32'h5566_7788); // R2 known
    idle(3);                                    // R3 hold
    maxAttrIdx = 4'd2;
    sendVecs(3); idle(1);                       // R6 R7 restart=1
    sendVecs(3); idle(1);                       // R7 restart=0
    setIdx(5'd15); maxAttrIdx = 4'd0;
    sendVecs(2);                                // R7 max=0
    @(negedge clk); idxWrEn = 1; idxWrData = 5'd15; wordWrEn = 1; wordWrData = 32'hDEAD_BEEF; // R9
    sendVecs(1); idle(1);
    setIdx(5'd20); sendVecs(2); idle(2);        // R4
    setIdx(5'd13); maxAttrIdx = 4'd3; sendVecs(7); idle(3); // R5 reach 15, R6
    finishRun();
  end
endmodule